// File: doc/BRIEF.md
# Execution Trace Pin Driver

This block gives a processor core a debug window with no software cost. After a one-time configuration write that names a 16-pin group and turns tracing on, it packs the core's status into one 16-bit word on every clock. That status is the two flags, the pipeline-advance signal, the condition result, the instruction-valid bit, the task number and the program counter. The block drives that word onto the chosen group of general-purpose output pins. A logic analyzer, or capture logic inside the chip, can then follow the core's execution cycle by cycle.

The block sits between the normal pin-output data path and the pins. The trace word is registered, so the pins always show the core state of the previous clock. Pins outside the chosen group, and every pin while tracing is off, carry the normal output data unchanged. A one-hot group-select output shows which group is taken over. Pin direction control stays outside the block.

Top module: `trace_port`

## Requirements
- R1: While reset is asserted and after it is released, tracing is off: `grp_sel` is 0 and `pin_out` equals `pin_out_norm` on all 64 bits.
- R2: The trace word places its fields from bit 15 down to bit 0 as follows: zero flag (bit 15), carry flag (bit 14), pipeline-advance (bit 13), condition-true (bit 12), instruction-valid (bit 11), task number (bits 10:9), program counter (bits 8:0).
- R3: While tracing is on, the selected pin group after a rising clock edge shows the trace word built from the core inputs sampled at that edge. This is a fixed one-cycle latency, and it updates every cycle with no further configuration writes.
- R4: When `cfg_wr` is 1 at a rising edge, `cfg_en` and `cfg_grp` are stored at that edge and take effect on the outputs immediately after it. Group index g covers pins 16*g+15 down to 16*g.
- R5: While tracing is on, every pin outside the selected group equals the same bit of `pin_out_norm`, combinationally.
- R6: A configuration write with `cfg_en` = 0 turns tracing off. After that edge all 64 pins equal `pin_out_norm` and `grp_sel` is 0.
- R7: While tracing is on, `grp_sel` has exactly one bit set, bit g for selected group g.
- R8: While `cfg_wr` is 0, changes on `cfg_en` and `cfg_grp` have no effect on the outputs.
- R9: Changing the selected group with a new write moves the trace word to the new group on the next edge, and the old group returns to normal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Trace enable value to store |
| cfg_grp | input | 2 | Pin-group index to store |
| core_z | input | 1 | Core zero flag |
| core_c | input | 1 | Core carry flag |
| core_go | input | 1 | High while the pipeline advances, low while stalled |
| core_cond | input | 1 | Condition of current instruction evaluated true |
| core_valid | input | 1 | Low when the instruction is cancelled after a taken branch |
| core_task | input | 2 | Current task number |
| core_pc | input | 9 | Program counter |
| pin_out_norm | input | 64 | Normal pin output data |
| pin_out | output | 64 | Pin output data after trace insertion |
| grp_sel | output | 4 | One-hot mask of the group carrying trace |

## Verification
The inline properties check on every cycle that the chosen group carries the core state of the previous edge, and that `grp_sel` stays one-hot and points at the stored group. They also check that untouched groups and a disabled port pass normal data, and that the stored configuration moves only on a write. Only the bench scenarios show the exact bit placement of each field against values computed by hand. They also show a group change carrying the trace to new pins while the old ones recover, and configuration inputs toggling without a write strobe while the output stays unchanged.

// File: rtl/trace_port_pkg.sv
package trace_port_pkg;

    parameter int PC_W       = 9;
    parameter int TASK_W     = 2;
    parameter int NUM_GROUPS = 4;

    // five single-bit status fields plus task and program counter
    localparam int TRACE_W = 5 + TASK_W + PC_W;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/trace_cfg_reg.sv
module trace_cfg_reg #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             en_in,
    input  logic [IDX_W-1:0] grp_in,
    output logic             en_q,
    output logic [IDX_W-1:0] grp_q
);

    typedef struct packed {
        logic             armed;
        logic             en;
        logic [IDX_W-1:0] grp;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        if (wr) begin
            st_d.en  = en_in;
            st_d.grp = grp_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign grp_q = st_q.grp;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !$past(wr)) |-> ($stable(en_q) && $stable(grp_q))); // R8

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(wr)) |-> (en_q == $past(en_in) && grp_q == $past(grp_in))); // R4

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_port_pkg::*;
#(
    parameter int P_PC_W   = PC_W,
    parameter int P_TASK_W = TASK_W,
    localparam int W       = 5 + P_TASK_W + P_PC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                z,
    input  logic                c,
    input  logic                go,
    input  logic                cond,
    input  logic                valid,
    input  logic [P_TASK_W-1:0] task_id,
    input  logic [P_PC_W-1:0]   pc,
    output logic [W-1:0]        word_q
);

    typedef struct packed {
        logic                zf;
        logic                cf;
        logic                adv;
        logic                cnd;
        logic                vld;
        logic [P_TASK_W-1:0] tsk;
        logic [P_PC_W-1:0]   pcv;
    } word_t;

    word_t w_d, w_q;

    always_comb begin
        w_d.zf  = z;
        w_d.cf  = c;
        w_d.adv = go;
        w_d.cnd = cond;
        w_d.vld = valid;
        w_d.tsk = task_id;
        w_d.pcv = pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign word_q = w_q;

endmodule

// File: rtl/trace_pin_mux.sv
module trace_pin_mux #(
    parameter int NGRP  = 4,
    parameter int GW    = 16,
    parameter int IDX_W = 2,
    localparam int PW   = NGRP * GW
) (
    input  logic             en,
    input  logic [IDX_W-1:0] grp,
    input  logic [GW-1:0]    word,
    input  logic [PW-1:0]    norm,
    output logic [PW-1:0]    pins,
    output logic [NGRP-1:0]  sel
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign sel[g] = en && (grp == IDX_W'(g));
        assign pins[g*GW +: GW] = sel[g] ? word : norm[g*GW +: GW];
    end

endmodule

// File: rtl/trace_port.sv
module trace_port
    import trace_port_pkg::*;
#(
    parameter int P_PC_W   = PC_W,
    parameter int P_TASK_W = TASK_W,
    parameter int P_NGRP   = NUM_GROUPS,
    localparam int GW      = 5 + P_TASK_W + P_PC_W,
    localparam int IDX_W   = idx_width(P_NGRP),
    localparam int PW      = P_NGRP * GW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_en,
    input  logic [IDX_W-1:0]    cfg_grp,
    input  logic                core_z,
    input  logic                core_c,
    input  logic                core_go,
    input  logic                core_cond,
    input  logic                core_valid,
    input  logic [P_TASK_W-1:0] core_task,
    input  logic [P_PC_W-1:0]   core_pc,
    input  logic [PW-1:0]       pin_out_norm,
    output logic [PW-1:0]       pin_out,
    output logic [P_NGRP-1:0]   grp_sel
);

    logic             en_q;
    logic [IDX_W-1:0] grp_q;
    logic [GW-1:0]    word_q;

    trace_cfg_reg #(.IDX_W(IDX_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .en_in  (cfg_en),
        .grp_in (cfg_grp),
        .en_q   (en_q),
        .grp_q  (grp_q)
    );

    trace_capture #(.P_PC_W(P_PC_W), .P_TASK_W(P_TASK_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .z       (core_z),
        .c       (core_c),
        .go      (core_go),
        .cond    (core_cond),
        .valid   (core_valid),
        .task_id (core_task),
        .pc      (core_pc),
        .word_q  (word_q)
    );

    trace_pin_mux #(.NGRP(P_NGRP), .GW(GW), .IDX_W(IDX_W)) u_mux (
        .en   (en_q),
        .grp  (grp_q),
        .word (word_q),
        .norm (pin_out_norm),
        .pins (pin_out),
        .sel  (grp_sel)
    );

    // checker state: marks that one full cycle has passed since reset
    typedef struct packed {
        logic seen;
    } chk_t;

    chk_t chk_d, chk_q;

    always_comb begin
        chk_d      = chk_q;
        chk_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    logic [GW-1:0] live_slice;
    assign live_slice = pin_out[int'(grp_q)*GW +: GW];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (grp_sel == '0)); // R1

    AST_TRACE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.seen && en_q) |->
        live_slice == $past({core_z, core_c, core_go, core_cond, core_valid, core_task, core_pc})); // R3

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> ($onehot(grp_sel) && grp_sel[grp_q])); // R7

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (pin_out == pin_out_norm && grp_sel == '0)); // R6

    for (genvar g = 0; g < P_NGRP; g++) begin : g_chk
        AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && grp_q != IDX_W'(g)) |->
            pin_out[g*GW +: GW] == pin_out_norm[g*GW +: GW]); // R5
    end

endmodule

// File: tb/sim_trace_port.sv
`timescale 1ns/1ps
module sim_trace_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0;
    logic [1:0]  cfg_grp = '0;
    logic        core_z = 1'b0, core_c = 1'b0, core_go = 1'b0, core_cond = 1'b0, core_valid = 1'b0;
    logic [1:0]  core_task = '0;
    logic [8:0]  core_pc = '0;
    logic [63:0] pin_out_norm = '0;
    logic [63:0] pin_out;
    logic [3:0]  grp_sel;

    always #2.5 clk = ~clk;

    trace_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_grp(cfg_grp),
        .core_z(core_z), .core_c(core_c), .core_go(core_go), .core_cond(core_cond),
        .core_valid(core_valid), .core_task(core_task), .core_pc(core_pc),
        .pin_out_norm(pin_out_norm), .pin_out(pin_out), .grp_sel(grp_sel)
    );

    typedef struct {
        logic [63:0] pins;
        logic [3:0]  sel;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0, n_fail = 0;
    bit   m_en = 1'b0;
    logic [1:0] m_grp = '0;
    bit   done = 1'b0;

    task automatic check(input string tag, input logic [63:0] pa, input logic [63:0] pe,
                         input logic [3:0] sa, input logic [3:0] se);
        n_run++;
        if (pa !== pe || sa !== se) begin
            n_fail++;
            $display("FAIL %s pins=%h sel=%b expected pins=%h sel=%b", tag, pa, sa, pe, se);
        end
    endtask

    // driver: drive one cycle of stimulus, push the outputs expected after the next edge
    task automatic step(input bit wr, input bit en, input logic [1:0] grp,
                        input logic [15:0] word, input logic [63:0] norm, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_wr = wr; cfg_en = en; cfg_grp = grp;
        {core_z, core_c, core_go, core_cond, core_valid, core_task, core_pc} = word;
        pin_out_norm = norm;
        if (wr) begin m_en = en; m_grp = grp; end
        e.pins = norm;
        e.sel  = '0;
        if (m_en) begin
            e.pins[m_grp*16 +: 16] = word;
            e.sel[m_grp] = 1'b1;
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, pin_out, e.pins, grp_sel, e.sel);
        end
    end

    function automatic logic [15:0] pack(input bit z, c, go, cond, vld,
                                         input logic [1:0] t, input logic [8:0] pc);
        return {z, c, go, cond, vld, t, pc};
    endfunction

    initial begin
        // R1: reset state with noisy config inputs
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_grp = 2'd2;
        pin_out_norm = 64'hA5A5_5A5A_0F0F_F0F0;
        repeat (3) @(negedge clk);
        check("R1 in reset", pin_out, pin_out_norm, grp_sel, 4'b0);
        cfg_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 16'hFFFF, 64'h1122_3344_5566_7788, "R1 after reset");

        // R2 / R3: enable on group 0, single fields one at a time
        step(1, 1, 0, pack(1,0,0,0,0,2'b00,9'h000), 64'h0, "R2 zero flag bit15");
        step(0, 0, 3, pack(0,1,0,0,0,2'b00,9'h000), 64'h0, "R2 carry bit14 R8");
        step(0, 0, 1, pack(0,0,1,0,0,2'b00,9'h000), 64'h0, "R2 go bit13 R8");
        step(0, 1, 2, pack(0,0,0,1,0,2'b00,9'h000), 64'h0, "R2 cond bit12 R8");
        step(0, 0, 0, pack(0,0,0,0,1,2'b00,9'h000), 64'h0, "R2 valid bit11");
        step(0, 0, 0, pack(0,0,0,0,0,2'b11,9'h000), 64'h0, "R2 task bits10:9");
        step(0, 0, 0, pack(0,0,0,0,0,2'b00,9'h1FF), 64'h0, "R2 pc bits8:0");
        // R3: continuous update, PC counting, GO toggling
        for (int i = 0; i < 6; i++)
            step(0, 0, 0, pack(i[0], i[1], ~i[0], 1, 1, i[1:0], 9'(9'h0F0 + i)),
                 64'hFFFF_FFFF_FFFF_FFFF, "R3 continuous R5");
        // R4 / R9: move to group 3, then group 1
        step(1, 1, 3, 16'h1234, 64'hDEAD_BEEF_CAFE_F00D, "R4 group3 R9");
        step(0, 0, 0, 16'hABCD, 64'h0123_4567_89AB_CDEF, "R5 others pass");
        step(1, 1, 1, 16'h5A5A, 64'h0123_4567_89AB_CDEF, "R9 move to group1 R7");
        step(1, 1, 2, 16'h0F0F, 64'hFFFF_0000_FFFF_0000, "R7 group2");
        // R8: config inputs wiggle without write
        step(0, 0, 0, 16'h7777, 64'h1111_2222_3333_4444, "R8 no write");
        step(0, 1, 3, 16'h8888, 64'h5555_6666_7777_8888, "R8 no write b");
        // R6: disable
        step(1, 0, 2, 16'hFFFF, 64'h9999_AAAA_BBBB_CCCC, "R6 disable");
        step(0, 1, 1, 16'hFFFF, 64'h0000_1111_2222_3333, "R6 stays off");
        step(0, 0, 0, 16'h0000, 64'h0, "R6 drain");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule